// File: doc/BRIEF.md
# Bidirectional Inter-Processor Mailbox

This block lets two processors that share one clock, called side A (the host) and side B (the guest), pass single bytes to each other. It has two channels, A-to-B and B-to-A. Each channel holds one byte latch and one flag. When the sender writes its data register, the byte travels through a short delay pipeline. After a fixed number of cycles it is captured into the latch and the flag is raised. The sender reads that flag as "busy" and the receiver reads it as "pending". When the receiver reads its data register, it gets the byte and the flag drops.

Each side has a plain synchronous bus-slave port with a select, a write enable, a one-bit register address and registered read data. Register address 0 is the data register and address 1 is the status register. A write to the data register while the side's outbound channel is busy is dropped, and a sticky overrun bit is recorded. The two flags also drive LED outputs directly.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, both flags, both overrun bits and both byte latches are zero: each status register reads 0x00, each data register reads 0x00, and both LED outputs are 0.
- R2: A bus cycle with sel=1, wr=1 and addr=0 launches the write byte. The byte is captured into the outbound latch, and the flag rises, on the STROBE_DLY-th rising edge after the write edge (default 2). Before that edge the flag stays 0.
- R3: Status bit 0 (busy) shows the side's outbound channel as occupied. It is 1 while a launched byte is still in the delay pipeline and while the outbound flag is set.
- R4: Status bit 1 (pending) shows the side's inbound flag, which is the same flag the other side sees as busy.
- R5: A bus cycle with sel=1, wr=0 and addr=0 returns the inbound latch and clears the inbound flag. The status register's other bits (7..3) always read 0.
- R6: The B-to-A channel behaves the same as the A-to-B channel and is independent of it: traffic on one channel leaves the other channel's flag and latch unchanged.
- R7: led_a2b equals the A-to-B flag and led_b2a equals the B-to-A flag.
- R8: A data write while the side's busy bit is 1 is dropped, leaving the latch unchanged, and sets status bit 2 (overrun). Overrun stays set until reset.
- R9: Reading the status register (addr=1) changes no flag, latch or overrun bit.
- R10: If a capture and a receiver data read fall on the same edge, the read returns the previous latch contents and the flag ends the cycle set, with the new byte in the latch.
- R11: rdata is registered. It shows the read result from the edge after the read cycle and holds its value when no read takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| a_sel | input | 1 | Side A bus select |
| a_wr | input | 1 | Side A write enable (0 = read) |
| a_addr | input | 1 | Side A register: 0 data, 1 status |
| a_wdata | input | DATA_W | Side A write byte |
| a_rdata | output | DATA_W | Side A registered read data |
| b_sel | input | 1 | Side B bus select |
| b_wr | input | 1 | Side B write enable (0 = read) |
| b_addr | input | 1 | Side B register: 0 data, 1 status |
| b_wdata | input | DATA_W | Side B write byte |
| b_rdata | output | DATA_W | Side B registered read data |
| led_a2b | output | 1 | A-to-B flag indicator |
| led_b2a | output | 1 | B-to-A flag indicator |

## Verification
The hardest case to reach is the one where the receiver's data read lands on exactly the edge where a delayed capture completes. This happens only when the read is issued STROBE_DLY cycles after an accepted write, while the flag is still clear. The bench issues side B's data read in the bus cycle right after side A's write task returns, so the read edge matches the capture edge. It then checks that the old byte is returned and that the pending flag and the new byte survive. A second hard window is the few cycles when a byte is in flight but the flag is not yet set. The bench reaches it by reading the sender's status right after a write and by watching the LED cycle by cycle.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;
  // register selector on each bus port
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
  // status register bit positions
  localparam int unsigned STAT_BUSY = 0;
  localparam int unsigned STAT_PEND = 1;
  localparam int unsigned STAT_OVR  = 2;
  localparam int unsigned STAT_BITS = 3;
endpackage

// File: rtl/ipc_strobe_delay.sv
module ipc_strobe_delay #(
  parameter int unsigned W   = 8,
  parameter int unsigned DLY = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         launch,
  input  logic [W-1:0] din,
  output logic         fire,
  output logic [W-1:0] dout,
  output logic         in_flight
);
  localparam int unsigned LAST = DLY - 1;

  logic [DLY-1:0] vld;
  logic [W-1:0]   dat [DLY];

  always_ff @(posedge clk) begin
    if (rst) vld[0] <= 1'b0;
    else     vld[0] <= launch;
    dat[0] <= din;
  end

  for (genvar i = 1; i < DLY; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) vld[i] <= 1'b0;
      else     vld[i] <= vld[i-1];
      dat[i] <= dat[i-1];
    end
  end

  assign fire      = vld[LAST];
  assign dout      = dat[LAST];
  assign in_flight = |vld;

  // a launch is only accepted when nothing is in flight
  assert_single_flight_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vld));
endmodule

// File: rtl/ipc_channel.sv
module ipc_channel #(
  parameter int unsigned W   = 8,
  parameter int unsigned DLY = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  input  logic         rd_clr,
  output logic         flag,
  output logic         busy,
  output logic         ovr,
  output logic [W-1:0] latch
);
  logic         fire;
  logic         in_flight;
  logic [W-1:0] dly_data;
  logic         accept;
  logic         reject;

  assign busy   = flag | in_flight;
  assign accept = wr_req & ~busy;
  assign reject = wr_req & busy;

  ipc_strobe_delay #(.W(W), .DLY(DLY)) u_dly (
    .clk(clk), .rst(rst), .launch(accept), .din(wdata),
    .fire(fire), .dout(dly_data), .in_flight(in_flight)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      ovr   <= 1'b0;
      latch <= '0;
    end else begin
      if (fire)        flag <= 1'b1;   // capture beats a same-edge clear
      else if (rd_clr) flag <= 1'b0;
      if (fire)   latch <= dly_data;
      if (reject) ovr   <= 1'b1;
    end
  end

  assert_capture_sets_flag_R10: assert property (@(posedge clk) disable iff (rst)
    fire |=> flag);
  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !fire) |=> !flag);
  assert_reject_overrun_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_req && busy) |=> ovr);
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ovr |=> ovr);
  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(latch));
endmodule

// File: rtl/ipc_bus_port.sv
module ipc_bus_port
  import ipc_mbx_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic         wr,
  input  logic         addr,
  input  logic [W-1:0] rx_latch,
  input  logic         busy_out,
  input  logic         pend_in,
  input  logic         ovr_out,
  output logic         wr_req,
  output logic         rd_clr,
  output logic [W-1:0] rdata
);
  logic         rd_any;
  logic [W-1:0] stat;

  assign rd_any = sel & ~wr;
  assign wr_req = sel &  wr & (addr == ADDR_DATA);
  assign rd_clr = rd_any & (addr == ADDR_DATA);

  always_comb begin
    stat            = '0;
    stat[STAT_BUSY] = busy_out;
    stat[STAT_PEND] = pend_in;
    stat[STAT_OVR]  = ovr_out;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_any) rdata <= (addr == ADDR_STAT) ? stat : rx_latch;
  end

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_any |=> $stable(rdata));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbx_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned STROBE_DLY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_sel,
  input  logic              a_wr,
  input  logic              a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_sel,
  input  logic              b_wr,
  input  logic              b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              led_a2b,
  output logic              led_b2a
);
  logic              a_wr_req, a_rd_clr, b_wr_req, b_rd_clr;
  logic              ab_flag, ab_busy, ab_ovr;
  logic              ba_flag, ba_busy, ba_ovr;
  logic [DATA_W-1:0] ab_latch, ba_latch;

  ipc_channel #(.W(DATA_W), .DLY(STROBE_DLY)) u_ch_a2b (
    .clk(clk), .rst(rst), .wr_req(a_wr_req), .wdata(a_wdata), .rd_clr(b_rd_clr),
    .flag(ab_flag), .busy(ab_busy), .ovr(ab_ovr), .latch(ab_latch)
  );

  ipc_channel #(.W(DATA_W), .DLY(STROBE_DLY)) u_ch_b2a (
    .clk(clk), .rst(rst), .wr_req(b_wr_req), .wdata(b_wdata), .rd_clr(a_rd_clr),
    .flag(ba_flag), .busy(ba_busy), .ovr(ba_ovr), .latch(ba_latch)
  );

  ipc_bus_port #(.W(DATA_W)) u_port_a (
    .clk(clk), .rst(rst), .sel(a_sel), .wr(a_wr), .addr(a_addr),
    .rx_latch(ba_latch), .busy_out(ab_busy), .pend_in(ba_flag), .ovr_out(ab_ovr),
    .wr_req(a_wr_req), .rd_clr(a_rd_clr), .rdata(a_rdata)
  );

  ipc_bus_port #(.W(DATA_W)) u_port_b (
    .clk(clk), .rst(rst), .sel(b_sel), .wr(b_wr), .addr(b_addr),
    .rx_latch(ab_latch), .busy_out(ba_busy), .pend_in(ab_flag), .ovr_out(ba_ovr),
    .wr_req(b_wr_req), .rd_clr(b_rd_clr), .rdata(b_rdata)
  );

  assign led_a2b = ab_flag;
  assign led_b2a = ba_flag;

  // a write on one side leaves the other channel's flag alone (R6)
  assert_channels_independent_R6: assert property (@(posedge clk) disable iff (rst)
    (a_wr_req && !a_rd_clr && !ba_busy) |=> !ba_flag);
  initial assert_width_R5: assert (DATA_W >= STAT_BITS && STROBE_DLY >= 1);
endmodule

// File: tb/ipc_mailbox_bench.sv
`timescale 1ns/1ps
module ipc_mailbox_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       a_sel, a_wr, a_addr, b_sel, b_wr, b_addr;
  logic [7:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic       led_a2b, led_b2a;
  int         tests = 0;
  int         fails = 0;
  logic [7:0] q;

  always #2.5 clk = ~clk;

  ipc_mailbox u_ipc_mailbox (
    .clk(clk), .rst(rst),
    .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .led_a2b(led_a2b), .led_b2a(led_b2a)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic drive(int side, logic s, logic w, logic ad, logic [7:0] d);
    if (side == 0) begin a_sel = s; a_wr = w; a_addr = ad; a_wdata = d; end
    else           begin b_sel = s; b_wr = w; b_addr = ad; b_wdata = d; end
  endtask

  task automatic do_write(int side, logic [7:0] d);
    @(negedge clk); drive(side, 1'b1, 1'b1, 1'b0, d);
    @(negedge clk); drive(side, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic do_read(int side, logic ad, output logic [7:0] r);
    @(negedge clk); drive(side, 1'b1, 1'b0, ad, 8'h00);
    @(negedge clk); drive(side, 1'b0, 1'b0, 1'b0, 8'h00);
    r = (side == 0) ? a_rdata : b_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    do_read(0, 1'b1, q); check("R1 A status", q, 8'h00);
    do_read(1, 1'b0, q); check("R1 B data", q, 8'h00);
    check("R1 leds", {6'd0, led_a2b, led_b2a}, 8'h00);
  endtask

  task automatic t_delay;
    do_write(0, 8'h5A);
    check("R2 flag low after write edge", {7'd0, led_a2b}, 8'h00);
    @(negedge clk); check("R2 flag low after edge 1", {7'd0, led_a2b}, 8'h00);
    @(negedge clk); check("R2 R7 flag high after edge 2", {7'd0, led_a2b}, 8'h01);
    do_read(1, 1'b1, q); check("R4 B pending", q, 8'h02);
    do_read(0, 1'b1, q); check("R3 A busy", q, 8'h01);
    do_read(1, 1'b1, q); check("R9 B status again", q, 8'h02);
    do_read(1, 1'b0, q); check("R5 B data", q, 8'h5A);
    check("R5 R7 flag cleared", {7'd0, led_a2b}, 8'h00);
    do_read(0, 1'b1, q); check("R5 A not busy", q, 8'h00);
  endtask

  task automatic t_inflight;
    do_write(0, 8'h33);
    do_read(0, 1'b1, q); check("R3 busy while in flight", q, 8'h01);
    idle(2);
    do_read(1, 1'b0, q); check("R11 B data 33", q, 8'h33);
    idle(2); check("R11 rdata holds", b_rdata, 8'h33);
  endtask

  task automatic t_overrun;
    do_write(0, 8'h11); idle(3);
    do_write(0, 8'h22); idle(3);
    do_read(0, 1'b1, q); check("R8 busy+overrun", q, 8'h05);
    do_read(1, 1'b0, q); check("R8 dropped byte kept old", q, 8'h11);
    do_read(0, 1'b1, q); check("R8 overrun sticky", q, 8'h04);
  endtask

  task automatic t_reverse;
    do_write(1, 8'hC3); idle(3);
    check("R6 R7 leds", {6'd0, led_a2b, led_b2a}, 8'h01);
    do_read(0, 1'b1, q); check("R6 A pending", q, 8'h06);
    do_read(1, 1'b1, q); check("R6 B busy", q, 8'h01);
    do_read(0, 1'b0, q); check("R6 A data", q, 8'hC3);
    do_read(1, 1'b1, q); check("R6 B idle", q, 8'h00);
    do_read(1, 1'b0, q); check("R6 A2B latch untouched", q, 8'h11);
  endtask

  task automatic t_collision;
    do_write(0, 8'h7E);
    do_read(1, 1'b0, q); check("R10 read returns old byte", q, 8'h11);
    check("R10 flag survives", {7'd0, led_a2b}, 8'h01);
    do_read(1, 1'b1, q); check("R10 B pending", q, 8'h02);
    do_read(1, 1'b0, q); check("R10 new byte", q, 8'h7E);
    do_read(1, 1'b1, q); check("R10 drained", q, 8'h00);
  endtask

  initial begin
    drive(0, 1'b0, 1'b0, 1'b0, 8'h00);
    drive(1, 1'b0, 1'b0, 1'b0, 8'h00);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_delay;
    t_inflight;
    t_overrun;
    t_reverse;
    t_collision;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule